// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge PWM Generator

This block drives the four switches of a full-bridge power stage. Each bridge leg has an upper and a lower gate. The two gates of a leg switch as a complementary pair at a fixed 50% duty cycle. Every leg runs at the same programmed switching period. The right leg lags the left leg by a programmable phase offset. That offset is the control variable: it sets how long the diagonally opposite switches conduct together, and that overlap transfers energy through the transformer. Left-leg edges open a power-transfer interval and right-leg edges close it.

Each leg has its own dead-time. This lets the turn-on delay of each leg be tuned on its own as the load changes. The period, the phase and both dead-times are sampled into shadow registers, and they take effect only at the start of a switching period. Two diagonal-overlap flags tell downstream synchronous-rectifier logic when each diagonal pair is conducting. A synchronous disable input turns every gate off.

Top module: `psfb_pwm`

## Requirements
- R1: Within one switching period P the left raw drive is high for counter positions 0 to P/2-1 and low for P/2 to P-1. The upper gate `gl_hi` follows the high half and the lower gate `gl_lo` follows the low half. The two gates of a leg are never high together.
- R2: The switching period equals `period_in` clock cycles, and any value below 4 is treated as 4. At a 100 MHz clock, values of 1000 and 666 give 100 kHz and about 150 kHz.
- R3: The right-leg drive (`gr_hi`, `gr_lo`) is the left-leg pattern delayed by the phase value, taken modulo the period.
- R4: A phase command larger than P/2 is clamped to P/2. At P/2 the diagonal overlap is at its maximum.
- R5: After every change of a leg's raw drive, both gates of that leg stay low for the number of cycles in that leg's own dead-time (`dt_left_in` or `dt_right_in`). The gate of the new state then turns on.
- R6: When a leg's dead-time is zero, its two gates are exact complements of each other.
- R7: New period, phase and dead-time values take effect only at the start of a switching period. A change in mid-period leaves the running period unaffected.
- R8: `diag_a` is high exactly while `gl_hi` and `gr_lo` are both high. `diag_b` is high exactly while `gl_lo` and `gr_hi` are both high.
- R9: While `dis` is high, all four gates and both flags are low from the next clock edge onward.
- R10: While `rst` is high, all outputs are low from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also loads the shadow registers |
| dis | input | 1 | Synchronous disable; forces all outputs low |
| period_in | input | CNT_W | Switching period in clock cycles |
| phase_in | input | CNT_W | Right-leg lag in clock cycles |
| dt_left_in | input | DT_W | Left-leg dead-time in cycles |
| dt_right_in | input | DT_W | Right-leg dead-time in cycles |
| gl_hi | output | 1 | Left-leg upper gate |
| gl_lo | output | 1 | Left-leg lower gate |
| gr_hi | output | 1 | Right-leg upper gate |
| gr_lo | output | 1 | Right-leg lower gate |
| diag_a | output | 1 | Diagonal gl_hi/gr_lo conducting |
| diag_b | output | 1 | Diagonal gl_lo/gr_hi conducting |

## Verification
Some properties are checked on every cycle. These are: the gates of one leg never conduct together, the counter stays inside the period, and the phase stays within its clamp. The shadow registers hold their values everywhere except at the period boundary. The flags match the gate pairs, and disable and reset drive every output low. Dead-time zero yields complementary gates. Other behaviour only the bench scenarios can show. That covers the on-time of each gate per period, the overlap lengths as they depend on the phase and on both dead-times, and the measured switching period. It also covers the deferred effect of a mid-period change, operation after disable is released, and phase clamping.

// File: rtl/psfb_pkg.sv
package psfb_pkg;
  // Smallest switching period the timebase accepts.
  localparam int MIN_PERIOD = 4;
  // Leg index used by the generate loop in the top.
  localparam int LEG_LEFT  = 0;
  localparam int LEG_RIGHT = 1;
  localparam int NUM_LEGS  = 2;
endpackage

// File: rtl/psfb_timebase.sv
module psfb_timebase
  import psfb_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] phase_in,
  input  logic [DT_W-1:0]  dt_left_in,
  input  logic [DT_W-1:0]  dt_right_in,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] per_q,
  output logic [CNT_W-1:0] half_q,
  output logic [CNT_W-1:0] ph_q,
  output logic [DT_W-1:0]  dtl_q,
  output logic [DT_W-1:0]  dtr_q
);
  localparam logic [CNT_W-1:0] PER_FLOOR = CNT_W'(MIN_PERIOD);

  logic [CNT_W-1:0] per_c, half_c, ph_c;
  logic             wrap;

  // Clamp the incoming command set before it is shadowed.
  always_comb begin
    per_c  = (period_in < PER_FLOOR) ? PER_FLOOR : period_in;
    half_c = per_c >> 1;
    ph_c   = (phase_in > half_c) ? half_c : phase_in;
  end

  assign wrap = (cnt_q == per_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || wrap) begin
      cnt_q  <= '0;
      per_q  <= per_c;
      half_q <= half_c;
      ph_q   <= ph_c;
      dtl_q  <= dt_left_in;
      dtr_q  <= dt_right_in;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/psfb_phase.sv
module psfb_phase #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] half,
  input  logic [CNT_W-1:0] ph,
  output logic             raw_l,
  output logic             raw_r
);
  logic [CNT_W:0] rpos;

  // Position of the right leg inside its own (lagging) period.
  always_comb begin
    if (cnt >= ph) rpos = {1'b0, cnt - ph};
    else           rpos = {1'b0, cnt} + {1'b0, per} - {1'b0, ph};
    raw_l = (cnt < half);
    raw_r = (rpos < {1'b0, half});
  end
endmodule

// File: rtl/psfb_leg.sv
module psfb_leg #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dis,
  input  logic            raw,
  input  logic [DT_W-1:0] dt,
  output logic            hi_d,
  output logic            lo_d,
  output logic            hi_q,
  output logic            lo_q
);
  localparam logic [DT_W:0] AGE_MAX = {1'b1, {DT_W{1'b0}}};
  localparam logic [DT_W:0] AGE_ONE = (DT_W+1)'(1);

  logic          raw_q;
  logic [DT_W:0] age_q, run;
  logic          pass;

  // run counts the cycles the raw drive has held its present value,
  // including this one; the gate opens once run exceeds the dead-time.
  always_comb begin
    if (raw != raw_q)         run = AGE_ONE;
    else if (age_q == AGE_MAX) run = age_q;
    else                      run = age_q + AGE_ONE;
    pass = (run > {1'b0, dt});
    hi_d = !dis &&  raw && pass;
    lo_d = !dis && !raw && pass;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= 1'b0;
      age_q <= '0;
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
    end else begin
      raw_q <= raw;
      age_q <= run;
      hi_q  <= hi_d;
      lo_q  <= lo_d;
    end
  end
endmodule

// File: rtl/psfb_pwm.sv
module psfb_pwm
  import psfb_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dis,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] phase_in,
  input  logic [DT_W-1:0]  dt_left_in,
  input  logic [DT_W-1:0]  dt_right_in,
  output logic             gl_hi,
  output logic             gl_lo,
  output logic             gr_hi,
  output logic             gr_lo,
  output logic             diag_a,
  output logic             diag_b
);
  logic [CNT_W-1:0]    cnt_s, per_s, half_s, ph_s;
  logic [DT_W-1:0]     dtl_s, dtr_s;
  logic [NUM_LEGS-1:0] raw_v, hi_d, lo_d, hi_q, lo_q;
  logic [DT_W-1:0]     dt_v [NUM_LEGS];

  psfb_timebase #(.CNT_W(CNT_W), .DT_W(DT_W)) i_tb (
    .clk(clk), .rst(rst),
    .period_in(period_in), .phase_in(phase_in),
    .dt_left_in(dt_left_in), .dt_right_in(dt_right_in),
    .cnt_q(cnt_s), .per_q(per_s), .half_q(half_s), .ph_q(ph_s),
    .dtl_q(dtl_s), .dtr_q(dtr_s)
  );

  psfb_phase #(.CNT_W(CNT_W)) i_ph (
    .cnt(cnt_s), .per(per_s), .half(half_s), .ph(ph_s),
    .raw_l(raw_v[LEG_LEFT]), .raw_r(raw_v[LEG_RIGHT])
  );

  assign dt_v[LEG_LEFT]  = dtl_s;
  assign dt_v[LEG_RIGHT] = dtr_s;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    psfb_leg #(.DT_W(DT_W)) i_leg (
      .clk(clk), .rst(rst), .dis(dis),
      .raw(raw_v[g]), .dt(dt_v[g]),
      .hi_d(hi_d[g]), .lo_d(lo_d[g]),
      .hi_q(hi_q[g]), .lo_q(lo_q[g])
    );
  end

  // Overlap flags registered alongside the gates so they align exactly.
  always_ff @(posedge clk) begin
    if (rst) begin
      diag_a <= 1'b0;
      diag_b <= 1'b0;
    end else begin
      diag_a <= hi_d[LEG_LEFT] & lo_d[LEG_RIGHT];
      diag_b <= lo_d[LEG_LEFT] & hi_d[LEG_RIGHT];
    end
  end

  assign gl_hi = hi_q[LEG_LEFT];
  assign gl_lo = lo_q[LEG_LEFT];
  assign gr_hi = hi_q[LEG_RIGHT];
  assign gr_lo = lo_q[LEG_RIGHT];
endmodule

// File: rtl/psfb_pwm_chk.sv
module psfb_pwm_chk #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             dis,
  input logic             gl_hi,
  input logic             gl_lo,
  input logic             gr_hi,
  input logic             gr_lo,
  input logic             diag_a,
  input logic             diag_b,
  input logic [CNT_W-1:0] cnt_s,
  input logic [CNT_W-1:0] per_s,
  input logic [CNT_W-1:0] half_s,
  input logic [CNT_W-1:0] ph_s,
  input logic [DT_W-1:0]  dtl_s,
  input logic [DT_W-1:0]  dtr_s
);
  p_leg_excl_r1: assert property (@(posedge clk) disable iff (rst)
    !(gl_hi && gl_lo) && !(gr_hi && gr_lo));

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_s < per_s);

  p_phase_clamp_r4: assert property (@(posedge clk) disable iff (rst)
    ph_s <= half_s);

  p_dt0_left_r6: assert property (@(posedge clk) disable iff (rst)
    (dtl_s == '0 && !dis) |=> (gl_hi != gl_lo));

  p_dt0_right_r6: assert property (@(posedge clk) disable iff (rst)
    (dtr_s == '0 && !dis) |=> (gr_hi != gr_lo));

  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt_s != per_s - CNT_W'(1)) |=>
      ($stable(per_s) && $stable(ph_s) && $stable(dtl_s) && $stable(dtr_s)));

  p_diag_a_r8: assert property (@(posedge clk) disable iff (rst)
    diag_a == (gl_hi && gr_lo));

  p_diag_b_r8: assert property (@(posedge clk) disable iff (rst)
    diag_b == (gl_lo && gr_hi));

  p_disable_r9: assert property (@(posedge clk) disable iff (rst)
    dis |=> !(gl_hi || gl_lo || gr_hi || gr_lo || diag_a || diag_b));

  p_reset_r10: assert property (@(posedge clk)
    rst |=> !(gl_hi || gl_lo || gr_hi || gr_lo || diag_a || diag_b));
endmodule

bind psfb_pwm psfb_pwm_chk #(.CNT_W(CNT_W), .DT_W(DT_W)) i_chk (
  .clk(clk), .rst(rst), .dis(dis),
  .gl_hi(gl_hi), .gl_lo(gl_lo), .gr_hi(gr_hi), .gr_lo(gr_lo),
  .diag_a(diag_a), .diag_b(diag_b),
  .cnt_s(cnt_s), .per_s(per_s), .half_s(half_s), .ph_s(ph_s),
  .dtl_s(dtl_s), .dtr_s(dtr_s)
);

// File: tb/test_psfb_pwm.sv
module test_psfb_pwm;
  localparam int CW = 16;
  localparam int DW = 8;
  localparam int SETTLE = 2500;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dis = 1'b0;
  logic [CW-1:0] per_i = 16'd1000;
  logic [CW-1:0] ph_i  = 16'd300;
  logic [DW-1:0] dtl_i = 8'd10;
  logic [DW-1:0] dtr_i = 8'd20;
  logic gl_hi, gl_lo, gr_hi, gr_lo, diag_a, diag_b;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  psfb_pwm #(.CNT_W(CW), .DT_W(DW)) i_psfb_pwm (
    .clk(clk), .rst(rst), .dis(dis),
    .period_in(per_i), .phase_in(ph_i),
    .dt_left_in(dtl_i), .dt_right_in(dtr_i),
    .gl_hi(gl_hi), .gl_lo(gl_lo), .gr_hi(gr_hi), .gr_lo(gr_lo),
    .diag_a(diag_a), .diag_b(diag_b)
  );

  // {period, phase, dead-time left, dead-time right}
  localparam logic [47:0] VEC [8] = '{
    {16'd1000, 16'd300,  8'd10, 8'd20},
    {16'd666,  16'd100,  8'd5,  8'd5 },
    {16'd1000, 16'd0,    8'd8,  8'd8 },
    {16'd1000, 16'd2000, 8'd10, 8'd30},
    {16'd200,  16'd50,   8'd0,  8'd0 },
    {16'd2,    16'd1,    8'd0,  8'd0 },
    {16'd400,  16'd150,  8'd40, 8'd0 },
    {16'd300,  16'd149,  8'd0,  8'd60}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R2: actual timeout expected completion");
    finish_run();
  end

  // Per-period gate on-times derived from the requirement text.
  function automatic void model(input int p_in, input int ph_in, input int dl, input int dr,
                                output int per, output int lh, output int ll,
                                output int rh, output int rl, output int da, output int db);
    int half, ph;
    per  = (p_in < 4) ? 4 : p_in;
    half = per / 2;
    ph   = (ph_in > half) ? half : ph_in;
    lh = 0; ll = 0; rh = 0; rl = 0; da = 0; db = 0;
    for (int k = 0; k < per; k++) begin
      int r;
      bit a, b, c, d;
      r = (k + per - ph) % per;
      a = (k < half) && (k >= dl);
      b = (k >= half) && (k - half >= dl);
      c = (r < half) && (r >= dr);
      d = (r >= half) && (r - half >= dr);
      lh += a; ll += b; rh += c; rl += d;
      da += (a && d);
      db += (b && c);
    end
  endfunction

  task automatic count_window(input int n, output int lh, output int ll, output int rh,
                              output int rl, output int da, output int db);
    lh = 0; ll = 0; rh = 0; rl = 0; da = 0; db = 0;
    repeat (n) begin
      @(negedge clk);
      lh += gl_hi; ll += gl_lo; rh += gr_hi; rl += gr_lo;
      da += diag_a; db += diag_b;
    end
  endtask

  task automatic wait_rise();
    logic pv;
    pv = gl_hi;
    forever begin
      @(negedge clk);
      if (gl_hi && !pv) break;
      pv = gl_hi;
    end
  endtask

  task automatic interval(output int p);
    logic pv;
    p  = 0;
    pv = gl_hi;
    forever begin
      @(negedge clk);
      p++;
      if (gl_hi && !pv) break;
      pv = gl_hi;
    end
  endtask

  initial begin
    int per, lh, ll, rh, rl, da, db;
    int m_lh, m_ll, m_rh, m_rl, m_da, m_db, mp;
    logic [15:0] vp, vph;
    logic [7:0]  vdl, vdr;

    // R10: outputs low while reset is held
    repeat (4) @(negedge clk);
    chk("R10 outputs in reset", int'({gl_hi, gl_lo, gr_hi, gr_lo, diag_a, diag_b}), 0);
    rst = 1'b0;

    for (int i = 0; i < 8; i++) begin
      {vp, vph, vdl, vdr} = VEC[i];
      per_i = vp; ph_i = vph; dtl_i = vdl; dtr_i = vdr;
      repeat (SETTLE) @(negedge clk);
      model(int'(vp), int'(vph), int'(vdl), int'(vdr), per, m_lh, m_ll, m_rh, m_rl, m_da, m_db);
      count_window(per, lh, ll, rh, rl, da, db);
      chk("R1 R5 left upper on-time", lh, m_lh);
      chk("R1 R5 left lower on-time", ll, m_ll);
      chk("R3 R4 R5 right upper on-time", rh, m_rh);
      chk("R3 R4 R5 right lower on-time", rl, m_rl);
      chk("R8 R3 R4 diag_a length", da, m_da);
      chk("R8 R3 diag_b length", db, m_db);
      wait_rise();
      interval(mp);
      chk("R2 switching period", mp, per);
    end

    // R6: zero dead-time gives exact complements
    per_i = 16'd200; ph_i = 16'd60; dtl_i = 8'd0; dtr_i = 8'd0;
    repeat (SETTLE) @(negedge clk);
    lh = 0;
    repeat (200) begin
      @(negedge clk);
      if (gl_hi == gl_lo || gr_hi == gr_lo) lh++;
    end
    chk("R6 non-complementary cycles", lh, 0);

    // R7: a mid-period period change waits for the boundary
    per_i = 16'd400; ph_i = 16'd100;
    repeat (SETTLE) @(negedge clk);
    wait_rise();
    per_i = 16'd600;
    interval(mp);
    chk("R7 period after mid-cycle change", mp, 400);
    interval(mp);
    chk("R7 next period uses new value", mp, 600);

    // R9: disable forces everything low, then operation resumes
    dis = 1'b1;
    lh = 0;
    repeat (30) begin
      @(negedge clk);
      lh += int'(gl_hi) + int'(gl_lo) + int'(gr_hi) + int'(gr_lo) + int'(diag_a) + int'(diag_b);
    end
    chk("R9 active outputs while disabled", lh, 0);
    dis = 1'b0;
    repeat (SETTLE) @(negedge clk);
    model(600, 100, 0, 0, per, m_lh, m_ll, m_rh, m_rl, m_da, m_db);
    count_window(per, lh, ll, rh, rl, da, db);
    chk("R9 left upper after release", lh, m_lh);
    chk("R9 diag_a after release", da, m_da);

    // R10: mid-run reset
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 outputs in mid-run reset", int'({gl_hi, gl_lo, gr_hi, gr_lo, diag_a, diag_b}), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    finish_run();
  end
endmodule